// File: doc/BRIEF.md
# Cell Window Capture Buffer

This block records a window of ATM cells from one selected stream into on-chip memory, so that the cells around an interesting moment can be read out and inspected afterwards. Each cell arrives as one wide word with a valid strobe. The block has two capture modes, and the mode is taken from `event_mode` when the block is armed. In manual mode, the block waits for a user trigger and then stores a full buffer of the cells that follow. In event mode, the block writes every cell into a circular buffer. When a trigger event arrives, it keeps the most recent half-window of cells from before the trigger and then fills the other half with the trigger cell and the cells after it.

Event triggers come from four externally detected strobes: cell loss, header error, PRBS error and sequence-number error. There are also two byte triggers. One fires when a selected byte of the cell equals a programmed value. The other fires when that byte differs from its value in the previous cell. Both byte triggers honour a per-bit exclusion mask. Once a capture completes, the buffer is frozen until the block is armed again. The read port addresses cells relative to the oldest stored cell, so reading addresses 0, 1, 2, ... returns the cells in arrival order. The index of the trigger cell is reported, along with whether a full pre-trigger half was available.

Top module: `cell_capture`

## Requirements
- R1: After reset the block is armed in manual mode, with `done`=0, `trig_index`=0 and `window_ok`=0.
- R2: In manual mode, a `manual_trig` pulse starts a capture. If `cell_valid` is high in the pulse cycle, that cell is stored first. The next DEPTH valid cells are stored, and `done` rises in the cycle after the last of them is accepted. After a manual capture, `trig_index`=0 and `window_ok`=1.
- R3: In event mode with at least PRE=DEPTH/2 earlier cells, a trigger keeps the PRE cells before the trigger cell. The trigger cell and the following cells fill the remaining DEPTH-PRE slots, and `done` rises after the last of them. After the capture, `trig_index`=PRE and `window_ok`=1.
- R4: If fewer than PRE cells arrived between arming and the trigger, all of them are kept. In that case `trig_index` equals their count and `window_ok`=0.
- R5: Event strobe `ev_strb` bit 0 (cell loss), bit 1 (header error), bit 2 (PRBS error) and bit 3 (sequence-number error) trigger only when the matching `src_en` bit 0..3 is set and `cell_valid` is high in the same cycle.
- R6: With `src_en` bit 4 set, a cell triggers when byte `byte_sel` of `cell_data` (bits 8*k+7..8*k) equals `match_val` on every bit whose `bit_mask` bit is 0. A `bit_mask` bit of 1 excludes that bit from the comparison.
- R7: With `src_en` bit 5 set, a cell triggers when its selected byte differs from the same byte of the previous valid cell since arming, on an unmasked bit. The first cell after arming has no reference and never triggers.
- R8: While `done`=1, cells, strobes and manual triggers are ignored and the stored contents do not change.
- R9: An `arm` pulse clears `done` and restarts capture in the mode given by `event_mode`. A cell offered in the `arm` cycle is neither stored nor used as a change reference.
- R10: `rd_data` returns, one clock after `rd_addr` is applied, the stored cell at position `rd_addr` counted from the oldest stored cell.
- R11: Manual mode ignores all event and byte triggers, and event mode ignores `manual_trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Re-arm pulse; latches the mode |
| event_mode | input | 1 | 1 = event capture, 0 = manual capture |
| manual_trig | input | 1 | User trigger pulse for manual mode |
| cell_valid | input | 1 | A cell is present on cell_data |
| cell_data | input | CELL_W | Cell word |
| ev_strb | input | 4 | Event strobes: loss, header, PRBS, sequence number |
| src_en | input | 6 | Trigger source enables: 4 strobes, value match, change |
| byte_sel | input | $clog2(CELL_W/8) | Watched byte of the cell |
| match_val | input | 8 | Value for the match trigger |
| bit_mask | input | 8 | 1 = bit excluded from byte triggers |
| rd_addr | input | $clog2(DEPTH) | Read position relative to the oldest cell |
| rd_data | output | CELL_W | Cell read out, one cycle latency |
| done | output | 1 | Capture complete, buffer frozen |
| trig_index | output | $clog2(DEPTH+1) | Position of the trigger cell |
| window_ok | output | 1 | Capture complete with a full pre-trigger half |

## Verification
Cells carry a running sequence number, and gaps in `cell_valid` come from a seeded random source. A read-back that matches the bench's record of sent cells therefore proves both the window start and the ordering. Random strobes from disabled sources, strobes in idle cycles and manual pulses in event mode are mixed into the stream. A premature trigger would shift the window and show up as a mismatch. The byte triggers are tried with near-miss values that differ only in masked bits, or only in unselected bytes, so an ignored mask is told apart from a correct one. Short and full pre-trigger histories separate the saturating pre-count from a plain one.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_DONE  = 2'd2
  } cap_state_e;

  // modular add on a ring of 'depth' slots; a < depth, b < 2*depth
  function automatic int unsigned ring_add(int unsigned a, int unsigned b,
                                           int unsigned depth);
    int unsigned s;
    s = a + b;
    if (s >= depth) s = s - depth;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // modular subtract on a ring of 'depth' slots; a, b < depth
  function automatic int unsigned ring_sub(int unsigned a, int unsigned b,
                                           int unsigned depth);
    return (a >= b) ? (a - b) : (a + depth - b);
  endfunction

  // equality of two bytes over the bits not excluded by mask (1 = excluded)
  function automatic logic masked_eq(logic [7:0] x, logic [7:0] y,
                                     logic [7:0] mask);
    return ((x ^ y) & ~mask) == 8'h00;
  endfunction

endpackage

// File: rtl/cap_trigger.sv
module cap_trigger
  import cap_pkg::*;
#(
  parameter int CELL_W = 32,
  parameter int SW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              track,
  input  logic              cell_valid,
  input  logic [CELL_W-1:0] cell_data,
  input  logic [SW-1:0]     byte_sel,
  input  logic [7:0]        match_val,
  input  logic [7:0]        bit_mask,
  input  logic [3:0]        ev_strb,
  input  logic [5:0]        src_en,
  output logic              trig_hit
);

  logic [7:0] sel_byte;
  logic [7:0] prev_byte;
  logic       have_prev;
  logic       ev_hit, val_hit, chg_hit;

  assign sel_byte = cell_data[{byte_sel, 3'b000} +: 8];
  assign ev_hit   = cell_valid && |(ev_strb & src_en[3:0]);
  assign val_hit  = cell_valid && masked_eq(sel_byte, match_val, bit_mask);
  assign chg_hit  = cell_valid && have_prev &&
                    !masked_eq(sel_byte, prev_byte, bit_mask);
  assign trig_hit = ev_hit || (src_en[4] && val_hit) || (src_en[5] && chg_hit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_prev <= 1'b0;
      prev_byte <= 8'h00;
    end else if (track && cell_valid) begin
      have_prev <= 1'b1;
      prev_byte <= sel_byte;
    end
  end

  assert_trig_needs_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> cell_valid);
  assert_no_reference_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !have_prev |-> !chg_hit);
  assert_cleared_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !have_prev);

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 1500,
  parameter int PRE   = DEPTH / 2,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          event_mode,
  input  logic          manual_trig,
  input  logic          cell_valid,
  input  logic          trig_hit,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          track,
  output logic          clear,
  output logic          done,
  output logic [CW-1:0] trig_index,
  output logic [AW-1:0] oldest,
  output logic          window_ok
);

  localparam int POST_EV = DEPTH - PRE;

  cap_state_e    state;
  logic          mode_r;
  logic [AW-1:0] wr_ptr, trig_ptr;
  logic [CW-1:0] pre_cnt, post_cnt, pre_kept;
  logic [CW-1:0] post_tgt, post_next;
  logic          armed, start_ev, start_man;

  assign armed     = (state == ST_ARMED);
  assign start_ev  = armed && mode_r && cell_valid && trig_hit && !arm;
  assign start_man = armed && !mode_r && manual_trig && !arm;
  assign post_tgt  = mode_r ? CW'(POST_EV) : CW'(DEPTH);
  assign wr_en     = !arm && cell_valid &&
                     ((armed && mode_r) || start_man || state == ST_POST);
  assign wr_addr   = wr_ptr;
  assign post_next = ((state == ST_POST) ? post_cnt : '0) + CW'(wr_en);
  assign track     = armed && mode_r && !arm;
  assign clear     = arm;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      state    <= ST_ARMED;
      mode_r   <= rst_n ? event_mode : 1'b0;
      wr_ptr   <= '0;
      trig_ptr <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      pre_kept <= '0;
    end else begin
      if (wr_en) wr_ptr <= AW'(ring_add(32'(wr_ptr), 32'd1, DEPTH));
      case (state)
        ST_ARMED: begin
          if (start_ev || start_man) begin
            trig_ptr <= start_ev ? wr_ptr : '0;
            pre_kept <= start_ev ? pre_cnt : '0;
            post_cnt <= post_next;
            state    <= (post_next == post_tgt) ? ST_DONE : ST_POST;
          end else if (wr_en && pre_cnt != CW'(PRE)) begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        ST_POST: begin
          if (wr_en) begin
            post_cnt <= post_next;
            if (post_next == post_tgt) state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign done       = (state == ST_DONE);
  assign trig_index = pre_kept;
  assign oldest     = AW'(ring_sub(32'(trig_ptr), 32'(pre_kept), DEPTH));
  assign window_ok  = done && (!mode_r || pre_kept == CW'(PRE));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  assert_no_write_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= CW'(PRE));
  assert_post_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    post_cnt <= post_tgt);
  assert_arm_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && state == ST_ARMED));
  assert_write_needs_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cell_valid);
  assert_manual_no_pre_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mode_r) |-> (pre_cnt == '0));

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DEPTH = 1500,
  parameter int W     = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/cell_capture.sv
module cell_capture
  import cap_pkg::*;
#(
  parameter int DEPTH  = 1500,
  parameter int CELL_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       event_mode,
  input  logic                       manual_trig,
  input  logic                       cell_valid,
  input  logic [CELL_W-1:0]          cell_data,
  input  logic [3:0]                 ev_strb,
  input  logic [5:0]                 src_en,
  input  logic [$clog2(CELL_W/8)-1:0] byte_sel,
  input  logic [7:0]                 match_val,
  input  logic [7:0]                 bit_mask,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [CELL_W-1:0]          rd_data,
  output logic                       done,
  output logic [$clog2(DEPTH+1)-1:0] trig_index,
  output logic                       window_ok
);

  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SW  = $clog2(CELL_W / 8);
  localparam int PRE = DEPTH / 2;

  logic          trig_hit, wr_en, track, clear;
  logic [AW-1:0] wr_addr, oldest, phys_rd;

  cap_trigger #(.CELL_W(CELL_W), .SW(SW)) u_trig (
    .clk(clk), .rst_n(rst_n), .clear(clear), .track(track),
    .cell_valid(cell_valid), .cell_data(cell_data), .byte_sel(byte_sel),
    .match_val(match_val), .bit_mask(bit_mask), .ev_strb(ev_strb),
    .src_en(src_en), .trig_hit(trig_hit)
  );

  cap_ctrl #(.DEPTH(DEPTH), .PRE(PRE), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .event_mode(event_mode),
    .manual_trig(manual_trig), .cell_valid(cell_valid), .trig_hit(trig_hit),
    .wr_en(wr_en), .wr_addr(wr_addr), .track(track), .clear(clear),
    .done(done), .trig_index(trig_index), .oldest(oldest),
    .window_ok(window_ok)
  );

  assign phys_rd = AW'(ring_add(32'(oldest), 32'(rd_addr), DEPTH));

  cap_mem #(.DEPTH(DEPTH), .W(CELL_W), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(cell_data),
    .rd_addr(phys_rd), .rd_data(rd_data)
  );

  assert_phys_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phys_rd < AW'(DEPTH));
  assert_window_ok_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    window_ok |-> done);

endmodule

// File: tb/cell_capture_test.sv
module cell_capture_test;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 1500;
  localparam int PRE    = DEPTH / 2;
  localparam int POST   = DEPTH - PRE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, event_mode = 1'b0, manual_trig = 1'b0;
  logic        cell_valid = 1'b0;
  logic [31:0] cell_data = '0;
  logic [3:0]  ev_strb = '0;
  logic [5:0]  src_en = '0;
  logic [1:0]  byte_sel = '0;
  logic [7:0]  match_val = '0, bit_mask = '0;
  logic [10:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        done, window_ok;
  logic [10:0] trig_index;

  int nchk = 0, nerr = 0, seq = 0;
  logic [31:0] hist [16384];
  bit finished = 1'b0;

  cell_capture uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .event_mode(event_mode),
    .manual_trig(manual_trig), .cell_valid(cell_valid), .cell_data(cell_data),
    .ev_strb(ev_strb), .src_en(src_en), .byte_sel(byte_sel),
    .match_val(match_val), .bit_mask(bit_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .trig_index(trig_index),
    .window_ok(window_ok)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_cell(int s, logic [7:0] b3);
    logic [7:0] b2;
    b2 = 8'(s * 7);
    return {b3, b2, 16'(s)};
  endfunction

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit v, logic [7:0] b3, logic [3:0] st, bit mt, bit ar);
    @(negedge clk);
    cell_valid  = v;
    cell_data   = mk_cell(seq, b3);
    ev_strb     = st;
    manual_trig = mt;
    arm         = ar;
    if (v) hist[seq] = cell_data;
    @(posedge clk);
    #1;
    if (v) seq++;
    cell_valid = 1'b0; ev_strb = '0; manual_trig = 1'b0; arm = 1'b0;
  endtask

  // n valid cells, random idle gaps; strobes on valid cells limited to 'noise'
  task automatic send(int n, logic [3:0] noise);
    for (int i = 0; i < n; i++) begin
      while ($urandom % 4 == 0) tick(1'b0, 8'h3C, 4'($urandom), 1'b0, 1'b0);
      tick(1'b1, 8'h3C, 4'($urandom) & noise, 1'b0, 1'b0);
    end
  endtask

  task automatic read_win(int addr0, int first, int count, string req);
    int bad = 0;
    int act = 0, exp = 0;
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      rd_addr = 11'(addr0 + i);
      @(posedge clk);
      #1;
      if (rd_data !== hist[first + i]) begin
        if (bad == 0) begin act = int'(rd_data[15:0]); exp = first + i; end
        bad++;
      end
    end
    chk(bad == 0, req, act, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int t, a;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(trig_index == 0, "R1 trig_index", int'(trig_index), 0);
    chk(window_ok == 1'b0, "R1 window_ok", int'(window_ok), 0);

    // R2/R11 manual capture; event strobes with all sources enabled ignored
    src_en = 6'h3F;
    send(20, 4'hF);
    t = seq;
    tick(1'b1, 8'h3C, 4'h0, 1'b1, 1'b0);
    send(DEPTH - 2, 4'hF);
    chk(done == 1'b0, "R2 done early", int'(done), 0);
    send(1, 4'h0);
    chk(done == 1'b1, "R2 done", int'(done), 1);
    chk(trig_index == 0, "R2 trig_index", int'(trig_index), 0);
    chk(window_ok == 1'b1, "R2 window_ok", int'(window_ok), 1);
    read_win(0, t, DEPTH, "R10 manual order R11");

    // R8 frozen after done
    send(40, 4'hF);
    tick(1'b1, 8'h3C, 4'hF, 1'b1, 1'b0);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
    read_win(0, t, 64, "R8 contents");

    // R3/R5/R9 event capture on cell loss, full pre-history
    src_en = 6'b000001; event_mode = 1'b1;
    tick(1'b1, 8'h3C, 4'h1, 1'b0, 1'b1);
    chk(done == 1'b0, "R9 done cleared", int'(done), 0);
    send(900, 4'b1110);
    tick(1'b0, 8'h3C, 4'hF, 1'b1, 1'b0);   // R11 manual pulse ignored
    t = seq;
    tick(1'b1, 8'h3C, 4'b0001, 1'b0, 1'b0);
    send(POST - 2, 4'h0);
    chk(done == 1'b0, "R3 done early", int'(done), 0);
    send(1, 4'h0);
    chk(done == 1'b1, "R3 done", int'(done), 1);
    chk(trig_index == 11'(PRE), "R3 trig_index", int'(trig_index), PRE);
    chk(window_ok == 1'b1, "R3 window_ok", int'(window_ok), 1);
    read_win(0, t - PRE, DEPTH, "R3 window R5");

    // R4 short pre-history, sequence-number strobe
    src_en = 6'b001000;
    tick(1'b0, 8'h3C, 4'h0, 1'b0, 1'b1);
    a = seq;
    send(100, 4'b0111);
    t = seq;
    tick(1'b1, 8'h3C, 4'b1000, 1'b0, 1'b0);
    send(POST - 1, 4'h0);
    chk(done == 1'b1, "R4 done", int'(done), 1);
    chk(trig_index == 11'(min_int(t - a, PRE)), "R4 trig_index",
        int'(trig_index), min_int(t - a, PRE));
    chk(window_ok == 1'b0, "R4 window_ok", int'(window_ok), 0);
    read_win(0, a, 100 + POST, "R4 window");

    // R6 value match on byte 3 with low nibble masked
    src_en = 6'b010000; byte_sel = 2'd3; match_val = 8'hA5; bit_mask = 8'h0F;
    tick(1'b0, 8'h3C, 4'h0, 1'b0, 1'b1);
    a = seq;
    send(200, 4'hF);
    tick(1'b1, 8'h55, 4'h0, 1'b0, 1'b0);
    tick(1'b1, 8'h5A, 4'h0, 1'b0, 1'b0);
    send(98, 4'hF);
    t = seq;
    tick(1'b1, 8'hA3, 4'h0, 1'b0, 1'b0);
    send(POST - 1, 4'h0);
    chk(trig_index == 11'(t - a), "R6 trig_index", int'(trig_index), t - a);
    read_win(t - a, t, 1, "R6 trigger cell");

    // R7 change detect, bit 0 masked, no reference after arm
    src_en = 6'b100000; bit_mask = 8'h01;
    tick(1'b1, 8'h77, 4'h0, 1'b0, 1'b0);
    tick(1'b0, 8'h3C, 4'h0, 1'b0, 1'b1);
    a = seq;
    send(10, 4'hF);
    tick(1'b1, 8'h3D, 4'h0, 1'b0, 1'b0);
    tick(1'b1, 8'h3C, 4'h0, 1'b0, 1'b0);
    send(5, 4'hF);
    t = seq;
    tick(1'b1, 8'h38, 4'h0, 1'b0, 1'b0);
    send(POST - 1, 4'h0);
    chk(done == 1'b1, "R7 done", int'(done), 1);
    chk(trig_index == 11'(t - a), "R7 trig_index", int'(trig_index), t - a);
    read_win(t - a, t, 1, "R7 trigger cell");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule